// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Operand Interlock

This block settles a conditional register-compare branch while the branch is still in the decode stage of a five-stage in-order pipeline. It selects the two compare operands, taking each one from the register-file read port or from the result held in the EX/MEM pipeline register. It tests them for equality with an XOR per bit followed by an OR across the result word. In parallel, a dedicated adder produces the branch destination. As a result, both the decision and the destination are ready when decode ends.

Fetch always proceeds down the fall-through path. When the branch is taken, the block asserts a flush that turns the single instruction fetched behind the branch into a bubble, so the taken penalty is one cycle. The block keeps a two-slot record of the older instructions still in flight: the one now in EX and the one now in MEM. Each slot holds the destination register, a write flag and a load flag. The record is fed each cycle from the instruction leaving decode. From it the block decides whether an operand can be used yet. If not, it holds the branch in decode and pushes a bubble into the record.

The stall depth therefore depends on the producer of the operand. It is zero when the value can be forwarded or read, one when an ALU result is a cycle away or a load is two instructions older, and two when a load sits directly ahead of the branch.

Top module: `id_branch_resolver`

## Requirements
- R1: The operands are equal exactly when the OR of their bitwise XOR is zero. With `id_bne` = 0 the branch is taken when the operands are equal. With `id_bne` = 1 it is taken when they differ.
- R2: `br_target` equals `id_pc4` plus the 16-bit offset, sign-extended and shifted left by two. It is valid in the same cycle the branch is presented.
- R3: If an operand register is written by the ALU instruction directly ahead of the branch, `stall_id` is high for exactly one cycle. In the next cycle the operand is taken from `exmem_val`.
- R4: If an operand register is written by a load two instructions ahead of the branch, `stall_id` is high for exactly one cycle.
- R5: If an operand register is written by a load directly ahead of the branch, `stall_id` is high for two consecutive cycles and never more. Each stalled cycle sends a bubble into the in-flight record.
- R6: An operand written by the second preceding ALU instruction is taken from `exmem_val`. An operand written by the third preceding instruction is taken from the register-file value. Neither case stalls.
- R7: `flush_if` is high exactly when `br_taken` is high. Neither is ever high in a cycle where `stall_id` is high.
- R8: Register 0 never causes a stall or a forward, even when an older instruction names it as its destination.
- R9: `stall_id` is high only when `id_valid` and `id_is_br` are both high. Ordinary instructions and bubbles never stall.
- R10: Asserting `rst_n` low empties the in-flight record at once, with no clock needed. The record stays empty until two rising edges after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| id_valid | input | 1 | Decode holds a real instruction (0 = bubble) |
| id_is_br | input | 1 | Decode instruction is a compare branch |
| id_bne | input | 1 | Compare sense: 0 = taken on equal, 1 = taken on unequal |
| id_rs | input | 5 | First compare source register |
| id_rt | input | 5 | Second compare source register |
| id_off | input | 16 | Signed word offset of the branch |
| id_pc4 | input | 32 | Address of the branch plus four |
| id_wr | input | 1 | Decode instruction writes a register |
| id_rd | input | 5 | Destination register of the decode instruction |
| id_ld | input | 1 | Decode instruction is a load |
| rf_rs_val | input | 32 | Register-file read value for `id_rs` |
| rf_rt_val | input | 32 | Register-file read value for `id_rt` |
| exmem_val | input | 32 | ALU result held in the EX/MEM pipeline register |
| br_taken | output | 1 | Branch resolved as taken this cycle |
| br_target | output | 32 | Branch destination address |
| stall_id | output | 1 | Hold PC and IF/ID and insert a bubble into EX |
| flush_if | output | 1 | Turn the instruction fetched behind the branch into a bubble |

## Verification
A wrong slot in the in-flight record shows up at the ports in the very next cycle that a branch names that register. The symptom is one of three: `stall_id` asserts for one cycle too many or too few, the stall run differs from the producer type, or `br_taken` follows a stale register-file value instead of `exmem_val`. The stimulus makes the forwarded and register-file values disagree, so a wrong operand selection always flips the branch outcome. A record that survives reset would show up as a stall on the first branch after reset that names the old load's destination.

// File: rtl/idbr_pkg.sv
package idbr_pkg;
  // Register address width of the pipeline.
  parameter int unsigned RA_W = 5;

  // What an in-flight instruction will write back.
  typedef struct packed {
    logic            wr;
    logic            ld;
    logic [RA_W-1:0] rd;
  } slot_t;

  localparam slot_t SLOT_EMPTY = '0;

  // True when the slot will produce register r (register 0 never counts).
  function automatic logic produces(input slot_t s, input logic [RA_W-1:0] r);
    return s.wr && (s.rd == r) && (r != '0);
  endfunction
endpackage

// File: rtl/idbr_track.sv
module idbr_track
  import idbr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic            id_valid,
  input  logic            id_is_br,
  input  logic [RA_W-1:0] id_rs,
  input  logic [RA_W-1:0] id_rt,
  input  logic            id_wr,
  input  logic [RA_W-1:0] id_rd,
  input  logic            id_ld,
  output logic            stall,
  output logic [1:0]      fwd_sel
);
  localparam int unsigned NSRC = 2;

  slot_t ex_q, mem_q, ex_d, mem_d;
  logic [RA_W-1:0] src [NSRC];
  logic [NSRC-1:0] not_ready;

  assign src[0] = id_rs;
  assign src[1] = id_rt;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // Any producer in EX, or a load in MEM, has no value to offer yet.
    assign not_ready[g] = produces(ex_q, src[g]) ||
                          (produces(mem_q, src[g]) && mem_q.ld);
    // An ALU result sitting in EX/MEM can be bypassed.
    assign fwd_sel[g]   = produces(mem_q, src[g]) && !mem_q.ld;
  end

  assign stall = id_valid && id_is_br && (|not_ready);

  // Next-state: a held branch leaves a bubble behind it.
  always_comb begin
    mem_d = ex_q;
    if (id_valid && !stall) begin
      ex_d = '{wr: id_wr, ld: id_ld, rd: id_rd};
    end else begin
      ex_d = SLOT_EMPTY;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ex_q  <= SLOT_EMPTY;
      mem_q <= SLOT_EMPTY;
    end else begin
      ex_q  <= ex_d;
      mem_q <= mem_d;
    end
  end
endmodule

// File: rtl/idbr_opsel.sv
module idbr_opsel #(
  parameter int unsigned XW = 32
) (
  input  logic [XW-1:0] rf_val,
  input  logic [XW-1:0] fwd_val,
  input  logic          use_fwd,
  output logic [XW-1:0] op
);
  always_comb begin
    op = use_fwd ? fwd_val : rf_val;
  end
endmodule

// File: rtl/idbr_resolve.sv
module idbr_resolve #(
  parameter int unsigned XW   = 32,
  parameter int unsigned OFFW = 16
) (
  input  logic [XW-1:0]   op_a,
  input  logic [XW-1:0]   op_b,
  input  logic            ne_sel,
  input  logic [XW-1:0]   pc4,
  input  logic [OFFW-1:0] off,
  output logic            cond,
  output logic [XW-1:0]   target
);
  localparam int unsigned PADW = XW - OFFW - 2;

  logic [XW-1:0] diff;
  logic          differ;

  assign diff   = op_a ^ op_b;
  assign differ = |diff;
  assign cond   = ne_sel ? differ : !differ;
  assign target = pc4 + {{PADW{off[OFFW-1]}}, off, 2'b00};
endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver
  import idbr_pkg::*;
#(
  parameter int unsigned XW   = 32,
  parameter int unsigned OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid,
  input  logic            id_is_br,
  input  logic            id_bne,
  input  logic [RA_W-1:0] id_rs,
  input  logic [RA_W-1:0] id_rt,
  input  logic [OFFW-1:0] id_off,
  input  logic [XW-1:0]   id_pc4,
  input  logic            id_wr,
  input  logic [RA_W-1:0] id_rd,
  input  logic            id_ld,
  input  logic [XW-1:0]   rf_rs_val,
  input  logic [XW-1:0]   rf_rt_val,
  input  logic [XW-1:0]   exmem_val,
  output logic            br_taken,
  output logic [XW-1:0]   br_target,
  output logic            stall_id,
  output logic            flush_if
);
  localparam int unsigned NSRC = 2;

  logic          rst_meta, rst_sync_n;
  logic [1:0]    fwd_sel;
  logic [XW-1:0] rf_v [NSRC];
  logic [XW-1:0] op   [NSRC];
  logic          cond;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  idbr_track u_track (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .id_valid   (id_valid),
    .id_is_br   (id_is_br),
    .id_rs      (id_rs),
    .id_rt      (id_rt),
    .id_wr      (id_wr),
    .id_rd      (id_rd),
    .id_ld      (id_ld),
    .stall      (stall_id),
    .fwd_sel    (fwd_sel)
  );

  assign rf_v[0] = rf_rs_val;
  assign rf_v[1] = rf_rt_val;

  for (genvar g = 0; g < NSRC; g++) begin : g_op
    idbr_opsel #(.XW(XW)) u_opsel (
      .rf_val  (rf_v[g]),
      .fwd_val (exmem_val),
      .use_fwd (fwd_sel[g]),
      .op      (op[g])
    );
  end

  idbr_resolve #(.XW(XW), .OFFW(OFFW)) u_resolve (
    .op_a   (op[0]),
    .op_b   (op[1]),
    .ne_sel (id_bne),
    .pc4    (id_pc4),
    .off    (id_off),
    .cond   (cond),
    .target (br_target)
  );

  assign br_taken = id_valid && id_is_br && !stall_id && cond;
  assign flush_if = br_taken;
endmodule

// File: rtl/id_branch_resolver_chk.sv
module id_branch_resolver_chk
  import idbr_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic            id_valid,
  input logic            id_is_br,
  input logic [RA_W-1:0] id_rs,
  input logic [RA_W-1:0] id_rt,
  input logic            stall_id,
  input logic            br_taken,
  input logic            flush_if
);
  logic [1:0] run_q;

  // Consecutive stall cycles seen before the current one.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q <= 2'd0;
    end else if (stall_id) begin
      run_q <= (run_q == 2'd3) ? 2'd3 : run_q + 2'd1;
    end else begin
      run_q <= 2'd0;
    end
  end

  p_taken_not_stalled_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (br_taken || flush_if) |-> !stall_id);

  p_stall_branch_only_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall_id |-> (id_valid && id_is_br));

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (id_valid && id_is_br && id_rs == '0 && id_rt == '0) |-> !stall_id);

  p_stall_run_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall_id |-> (run_q < 2'd2));
endmodule

bind id_branch_resolver id_branch_resolver_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .id_valid   (id_valid),
  .id_is_br   (id_is_br),
  .id_rs      (id_rs),
  .id_rt      (id_rt),
  .stall_id   (stall_id),
  .br_taken   (br_taken),
  .flush_if   (flush_if)
);

// File: tb/id_branch_resolver_tb.sv
`timescale 1ns/100ps
module id_branch_resolver_tb;
  localparam real CLK_HALF = 2.5;
  localparam int  NVEC     = 24;

  typedef struct packed {
    logic        v, br, bne;
    logic [4:0]  rs, rt;
    logic        wr;
    logic [4:0]  rd;
    logic        ld;
    logic [31:0] a, b, f;
    logic        st, tk;
  } vec_t;

  // One entry per decode cycle; a held branch is repeated in the next entry.
  localparam vec_t VT [NVEC] = '{
    '{1'b0,1'b0,1'b0,5'd0,5'd0,1'b0,5'd0,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 0 bubble
    '{1'b1,1'b0,1'b0,5'd1,5'd2,1'b1,5'd3,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 1 alu -> r3
    '{1'b1,1'b1,1'b0,5'd3,5'd4,1'b0,5'd0,1'b0,32'd5,32'd5,32'd0,1'b1,1'b0},  // 2 beq r3 held
    '{1'b1,1'b1,1'b0,5'd3,5'd4,1'b0,5'd0,1'b0,32'd5,32'd7,32'd7,1'b0,1'b1},  // 3 beq fwd a
    '{1'b0,1'b0,1'b0,5'd0,5'd0,1'b0,5'd0,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 4 flushed
    '{1'b1,1'b0,1'b0,5'd1,5'd0,1'b1,5'd8,1'b1,32'd0,32'd0,32'd0,1'b0,1'b0},  // 5 load -> r8
    '{1'b1,1'b1,1'b1,5'd8,5'd9,1'b0,5'd0,1'b0,32'd10,32'd11,32'd0,1'b1,1'b0}, // 6 bne held
    '{1'b1,1'b1,1'b1,5'd8,5'd9,1'b0,5'd0,1'b0,32'd10,32'd11,32'd0,1'b1,1'b0}, // 7 bne held
    '{1'b1,1'b1,1'b1,5'd8,5'd9,1'b0,5'd0,1'b0,32'd10,32'd11,32'd11,1'b0,1'b1},// 8 bne from rf
    '{1'b0,1'b0,1'b0,5'd0,5'd0,1'b0,5'd0,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 9 bubble
    '{1'b1,1'b0,1'b0,5'd1,5'd0,1'b1,5'd6,1'b1,32'd0,32'd0,32'd0,1'b0,1'b0},  // 10 load -> r6
    '{1'b1,1'b0,1'b0,5'd1,5'd1,1'b1,5'd2,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 11 alu -> r2
    '{1'b1,1'b1,1'b0,5'd6,5'd0,1'b0,5'd0,1'b0,32'd1,32'd0,32'd0,1'b1,1'b0},  // 12 beq r6 held
    '{1'b1,1'b1,1'b0,5'd6,5'd0,1'b0,5'd0,1'b0,32'd0,32'd0,32'd55,1'b0,1'b1}, // 13 beq resolves
    '{1'b1,1'b0,1'b0,5'd1,5'd1,1'b1,5'd0,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 14 alu -> r0
    '{1'b1,1'b1,1'b0,5'd0,5'd0,1'b0,5'd0,1'b0,32'd0,32'd0,32'd0,1'b0,1'b1},  // 15 beq r0,r0
    '{1'b1,1'b0,1'b0,5'd1,5'd1,1'b1,5'd5,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 16 alu -> r5
    '{1'b1,1'b0,1'b0,5'd1,5'd1,1'b1,5'd7,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 17 alu -> r7
    '{1'b1,1'b0,1'b0,5'd1,5'd1,1'b1,5'd1,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 18 alu -> r1
    '{1'b1,1'b1,1'b0,5'd5,5'd7,1'b0,5'd0,1'b0,32'd20,32'd20,32'd21,1'b0,1'b0},// 19 beq r5,r7
    '{1'b1,1'b1,1'b1,5'd1,5'd4,1'b0,5'd0,1'b0,32'd3,32'd4,32'd4,1'b0,1'b0},  // 20 bne r1 fwd
    '{1'b1,1'b0,1'b0,5'd1,5'd1,1'b1,5'd9,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0},  // 21 alu -> r9
    '{1'b1,1'b0,1'b0,5'd9,5'd9,1'b1,5'd10,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0}, // 22 alu uses r9
    '{1'b0,1'b0,1'b0,5'd0,5'd0,1'b0,5'd0,1'b0,32'd0,32'd0,32'd0,1'b0,1'b0}   // 23 bubble
  };

  logic        clk, rst_n;
  logic        id_valid, id_is_br, id_bne, id_wr, id_ld;
  logic [4:0]  id_rs, id_rt, id_rd;
  logic [15:0] id_off;
  logic [31:0] id_pc4, rf_rs_val, rf_rt_val, exmem_val;
  logic        br_taken, stall_id, flush_if;
  logic [31:0] br_target;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  id_branch_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_is_br(id_is_br),
    .id_bne(id_bne), .id_rs(id_rs), .id_rt(id_rt), .id_off(id_off),
    .id_pc4(id_pc4), .id_wr(id_wr), .id_rd(id_rd), .id_ld(id_ld),
    .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val), .exmem_val(exmem_val),
    .br_taken(br_taken), .br_target(br_target), .stall_id(stall_id),
    .flush_if(flush_if)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input vec_t x);
    id_valid = x.v;  id_is_br = x.br; id_bne = x.bne;
    id_rs = x.rs;    id_rt = x.rt;    id_wr = x.wr;
    id_rd = x.rd;    id_ld = x.ld;
    rf_rs_val = x.a; rf_rt_val = x.b; exmem_val = x.f;
  endtask

  function automatic string tag_of(input int i);
    case (i)
      2, 3:     return "R3";
      6, 7, 8:  return "R5";
      12, 13:   return "R4";
      14, 15:   return "R8";
      19, 20:   return "R6";
      22:       return "R9";
      default:  return "R1";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    vec_t nop, x;
    nop = '0;
    rst_n = 1'b0;
    put(nop);
    id_off = 16'h0004;
    id_pc4 = 32'h0000_0100;
    #3;
    // R10: reset state, empty record.
    chk("R10 stall in reset", {31'd0, stall_id}, 32'd0);
    chk("R10 taken in reset", {31'd0, br_taken}, 32'd0);
    chk("R10 flush in reset", {31'd0, flush_if}, 32'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Stimulus table.
    for (int i = 0; i < NVEC; i++) begin
      #1 put(VT[i]);
      #2;
      chk({tag_of(i), " stall"}, {31'd0, stall_id}, {31'd0, VT[i].st});
      chk({tag_of(i), " taken"}, {31'd0, br_taken}, {31'd0, VT[i].tk});
      chk("R7 flush", {31'd0, flush_if}, {31'd0, VT[i].tk});
      @(posedge clk);
    end
    #1 put(nop);
    @(posedge clk);

    // R2 / R1: target and compare sense.
    x = '0; x.v = 1; x.br = 1; x.rs = 5'd1; x.rt = 5'd2; x.a = 32'h33; x.b = 32'h33;
    #1 put(x); id_pc4 = 32'h0000_1000; id_off = 16'hFFFE;
    #2;
    chk("R2 target backward", br_target, 32'h0000_0FF8);
    chk("R1 beq equal taken", {31'd0, br_taken}, 32'd1);
    @(posedge clk);
    x.a = 32'hA5; x.b = 32'hA4;
    #1 put(x); id_off = 16'h0010;
    #2;
    chk("R2 target forward", br_target, 32'h0000_1040);
    chk("R1 beq unequal not taken", {31'd0, br_taken}, 32'd0);
    @(posedge clk);
    x.bne = 1; x.a = 32'hFFFF_FFFF; x.b = 32'h7FFF_FFFF;
    #1 put(x);
    #2 chk("R1 bne msb differs taken", {31'd0, br_taken}, 32'd1);
    @(posedge clk);
    x.a = 32'd0; x.b = 32'd0;
    #1 put(x);
    #2 chk("R1 bne equal not taken", {31'd0, br_taken}, 32'd0);
    @(posedge clk);

    // R10: asynchronous reset empties the record mid-run.
    x = '0; x.v = 1; x.wr = 1; x.ld = 1; x.rd = 5'd12; x.rs = 5'd1;
    #1 put(x);
    @(posedge clk);
    x = '0; x.v = 1; x.br = 1; x.rs = 5'd12; x.rt = 5'd0;
    #1 put(x);
    #2 chk("R5 load ahead stalls", {31'd0, stall_id}, 32'd1);
    rst_n = 1'b0;
    #1 chk("R10 reset clears record", {31'd0, stall_id}, 32'd0);
    @(posedge clk);
    #1 put(nop); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 put(x);
    #2 chk("R10 clean after release", {31'd0, stall_id}, 32'd0);
    @(posedge clk);
    finish_run();
  end
endmodule